// File: doc/BRIEF.md
# Debug Access Protection Controller

This block decides, for one core's memory access port, whether an external debugger may perform ordinary transfers, whether it may perform secure transfers, and whether the mass-erase commands from the debug link and from the flash controller are honoured. It combines three non-volatile lock settings with two pairs of 32-bit disable registers. One pair is written by firmware on the CPU side and the other by the debugger over the debug link.

Access opens only when the relevant lock setting is clear and the firmware-side and debugger-side values of a pair are identical. Firmware and debugger therefore have to agree on a value before debug is granted. The lock settings are captured once after reset and held until the next reset. A build parameter removes the secure path for cores without a security extension.

Top module: `dbg_prot_ctrl`

## Requirements
- R1: While rst_ni is low, every output is 0. After reset, all four disable registers read as zero, so with all locks clear and no writes, both enables become 1.
- R2: dbgen_o is 1 only when the captured debug lock (nv_dbg_lock_i, 1 = locked) is clear and the CPU-side and debugger-side non-secure disable registers hold equal values. Any other combination gives 0.
- R3: spiden_o is 1 only when the captured secure lock (nv_sec_lock_i, 1 = locked) is clear and the CPU-side and debugger-side secure disable registers hold equal values.
- R4: spiden_o is never 1 unless the R2 condition for dbgen_o also holds.
- R5: erase_ok_o is 1 exactly when the captured erase lock (nv_erase_lock_i, 1 = locked) is clear. dbg_erase_o and nvm_erase_o pass dbg_erase_req_i and nvm_erase_req_i only while erase_ok_o is 1.
- R6: The three lock inputs are captured on the first rising clock edge after reset release. Before that edge both enables and erase_ok_o are 0. Later changes on the lock inputs have no effect until the next reset.
- R7: status_o[0] reports whether transfers are permitted and status_o[1] reports whether secure transfers are permitted. They equal dbgen_o and spiden_o.
- R8: The enables and erase_ok_o are registered. A write accepted at a clock edge is reflected in them right after that same edge.
- R9: A CPU-side write and a debugger-side write in the same cycle both take effect at that edge.
- R10: The select input picks the register, with 0 = non-secure disable and 1 = secure disable. A write to one register leaves the other unchanged.
- R11: With HAS_SECURE = 0, spiden_o is tied to 0 and dbgen_o follows R2 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nv_dbg_lock_i | input | 1 | Non-volatile debug lock, 1 = locked |
| nv_sec_lock_i | input | 1 | Non-volatile secure debug lock, 1 = locked |
| nv_erase_lock_i | input | 1 | Non-volatile erase lock, 1 = locked |
| cpu_we_i | input | 1 | CPU-side write strobe |
| cpu_sel_i | input | 1 | CPU-side register select (0 non-secure, 1 secure) |
| cpu_wdata_i | input | DW | CPU-side write data |
| dbg_we_i | input | 1 | Debugger-side write strobe |
| dbg_sel_i | input | 1 | Debugger-side register select (0 non-secure, 1 secure) |
| dbg_wdata_i | input | DW | Debugger-side write data |
| dbg_erase_req_i | input | 1 | Mass-erase request from the debug link |
| nvm_erase_req_i | input | 1 | Mass-erase request from the flash controller |
| dbgen_o | output | 1 | Debug transfers enabled |
| spiden_o | output | 1 | Secure debug transfers enabled |
| erase_ok_o | output | 1 | Mass erase permitted |
| dbg_erase_o | output | 1 | Gated debug-link erase command |
| nvm_erase_o | output | 1 | Gated flash-controller erase command |
| status_o | output | 2 | {secure permitted, permitted} |

## Verification
Two things can land on the same edge: a firmware write and a debugger write. They may target the same register index or different ones. The bench drives both write ports in one cycle, once with matching values that open access and once with a split target that breaks the non-secure pair. The scoreboard then checks that the enables reflect both new register values right after that edge. A mass-erase request is also placed in the same cycle as a pair of writes, and the bench checks that the erase grant depends only on the captured erase lock.

// File: rtl/dbg_prot_pkg.sv
package dbg_prot_pkg;
  typedef enum logic {
    SEL_NS  = 1'b0,
    SEL_SEC = 1'b1
  } dis_sel_e;

  // 1 = locked
  typedef struct packed {
    logic dbg;
    logic sec;
    logic erase;
  } lock_cfg_t;

  localparam lock_cfg_t LOCK_ALL = '{dbg: 1'b1, sec: 1'b1, erase: 1'b1};
endpackage

// File: rtl/dbg_prot_nvcap.sv
module dbg_prot_nvcap
  import dbg_prot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  lock_cfg_t cfg_i,
  output lock_cfg_t cfg_o,
  output logic      valid_o
);
  lock_cfg_t cfg_q;
  logic      valid_q;

  // locked until the one-time capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= LOCK_ALL;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      cfg_q   <= cfg_i;
      valid_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dbg_prot_regs.sv
module dbg_prot_regs
  import dbg_prot_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          HAS_SECURE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  dis_sel_e      sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ns_q_o,
  output logic [DW-1:0] ns_d_o,
  output logic [DW-1:0] s_q_o,
  output logic [DW-1:0] s_d_o
);
  logic [DW-1:0] ns_q;

  assign ns_d_o = (we_i && sel_i == SEL_NS) ? wdata_i : ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ns_q <= '0;
    else         ns_q <= ns_d_o;
  end
  assign ns_q_o = ns_q;

  if (HAS_SECURE) begin : g_sec
    logic [DW-1:0] s_q;
    assign s_d_o = (we_i && sel_i == SEL_SEC) ? wdata_i : s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s_q <= '0;
      else         s_q <= s_d_o;
    end
    assign s_q_o = s_q;
  end else begin : g_nosec
    assign s_d_o = '0;
    assign s_q_o = '0;
  end
endmodule

// File: rtl/dbg_prot_grant.sv
module dbg_prot_grant
  import dbg_prot_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          HAS_SECURE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  lock_cfg_t     cfg_i,
  input  logic          valid_i,
  input  logic [DW-1:0] cpu_ns_d_i,
  input  logic [DW-1:0] dbg_ns_d_i,
  input  logic [DW-1:0] cpu_s_d_i,
  input  logic [DW-1:0] dbg_s_d_i,
  output logic          dbgen_o,
  output logic          spiden_o,
  output logic          erase_ok_o
);
  logic dbg_nxt, erase_nxt;
  logic dbgen_q, erase_q;

  // next-state register values used so a write shows at its own edge
  assign dbg_nxt   = valid_i && !cfg_i.dbg && (cpu_ns_d_i == dbg_ns_d_i);
  assign erase_nxt = valid_i && !cfg_i.erase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbgen_q <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      dbgen_q <= dbg_nxt;
      erase_q <= erase_nxt;
    end
  end

  assign dbgen_o    = dbgen_q;
  assign erase_ok_o = erase_q;

  if (HAS_SECURE) begin : g_sec
    logic sec_nxt, spiden_q;
    assign sec_nxt = dbg_nxt && !cfg_i.sec && (cpu_s_d_i == dbg_s_d_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) spiden_q <= 1'b0;
      else         spiden_q <= sec_nxt;
    end
    assign spiden_o = spiden_q;
  end else begin : g_nosec
    assign spiden_o = 1'b0;
  end
endmodule

// File: rtl/dbg_prot_ctrl.sv
module dbg_prot_ctrl
  import dbg_prot_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          HAS_SECURE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nv_dbg_lock_i,
  input  logic          nv_sec_lock_i,
  input  logic          nv_erase_lock_i,
  input  logic          cpu_we_i,
  input  logic          cpu_sel_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          dbg_we_i,
  input  logic          dbg_sel_i,
  input  logic [DW-1:0] dbg_wdata_i,
  input  logic          dbg_erase_req_i,
  input  logic          nvm_erase_req_i,
  output logic          dbgen_o,
  output logic          spiden_o,
  output logic          erase_ok_o,
  output logic          dbg_erase_o,
  output logic          nvm_erase_o,
  output logic [1:0]    status_o
);
  lock_cfg_t     nv_in, cfg_q;
  logic          cap_valid;
  logic [DW-1:0] cpu_ns_q, cpu_ns_d, cpu_s_q, cpu_s_d;
  logic [DW-1:0] dbg_ns_q, dbg_ns_d, dbg_s_q, dbg_s_d;

  assign nv_in = '{dbg: nv_dbg_lock_i, sec: nv_sec_lock_i, erase: nv_erase_lock_i};

  dbg_prot_nvcap u_nvcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (nv_in),
    .cfg_o  (cfg_q),
    .valid_o(cap_valid)
  );

  dbg_prot_regs #(.DW(DW), .HAS_SECURE(HAS_SECURE)) u_cpu_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cpu_we_i),
    .sel_i  (dis_sel_e'(cpu_sel_i)),
    .wdata_i(cpu_wdata_i),
    .ns_q_o (cpu_ns_q),
    .ns_d_o (cpu_ns_d),
    .s_q_o  (cpu_s_q),
    .s_d_o  (cpu_s_d)
  );

  dbg_prot_regs #(.DW(DW), .HAS_SECURE(HAS_SECURE)) u_dbg_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (dbg_we_i),
    .sel_i  (dis_sel_e'(dbg_sel_i)),
    .wdata_i(dbg_wdata_i),
    .ns_q_o (dbg_ns_q),
    .ns_d_o (dbg_ns_d),
    .s_q_o  (dbg_s_q),
    .s_d_o  (dbg_s_d)
  );

  dbg_prot_grant #(.DW(DW), .HAS_SECURE(HAS_SECURE)) u_grant (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_q),
    .valid_i   (cap_valid),
    .cpu_ns_d_i(cpu_ns_d),
    .dbg_ns_d_i(dbg_ns_d),
    .cpu_s_d_i (cpu_s_d),
    .dbg_s_d_i (dbg_s_d),
    .dbgen_o   (dbgen_o),
    .spiden_o  (spiden_o),
    .erase_ok_o(erase_ok_o)
  );

  assign dbg_erase_o = dbg_erase_req_i && erase_ok_o;
  assign nvm_erase_o = nvm_erase_req_i && erase_ok_o;
  assign status_o    = {spiden_o, dbgen_o};
endmodule

// File: rtl/dbg_prot_chk.sv
module dbg_prot_chk
  import dbg_prot_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dbgen_o,
  input logic          spiden_o,
  input logic          dbg_erase_o,
  input logic          nvm_erase_o,
  input logic          cap_valid,
  input lock_cfg_t     cfg_q,
  input logic [DW-1:0] cpu_ns_q,
  input logic [DW-1:0] dbg_ns_q,
  input logic [DW-1:0] cpu_s_q,
  input logic [DW-1:0] dbg_s_q
);
  p_dbg_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbgen_o |-> (cpu_ns_q == dbg_ns_q) && !cfg_q.dbg && cap_valid);

  p_sec_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spiden_o |-> (cpu_s_q == dbg_s_q) && !cfg_q.sec);

  p_sec_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spiden_o |-> dbgen_o);

  p_erase_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_erase_o || nvm_erase_o) |-> !cfg_q.erase && cap_valid);

  p_cfg_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid && $past(cap_valid)) |-> $stable(cfg_q));

  p_cap_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_valid |=> cap_valid);
endmodule

bind dbg_prot_ctrl dbg_prot_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbgen_o    (dbgen_o),
  .spiden_o   (spiden_o),
  .dbg_erase_o(dbg_erase_o),
  .nvm_erase_o(nvm_erase_o),
  .cap_valid  (cap_valid),
  .cfg_q      (cfg_q),
  .cpu_ns_q   (cpu_ns_q),
  .dbg_ns_q   (dbg_ns_q),
  .cpu_s_q    (cpu_s_q),
  .dbg_s_q    (dbg_s_q)
);

// File: tb/dbg_prot_ctrl_test.sv
module dbg_prot_ctrl_test;
  localparam int CLK_P = 10;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          nv_d = 1'b0, nv_s = 1'b0, nv_e = 1'b0;
  logic          cwe = 1'b0, csel = 1'b0, dwe = 1'b0, dsel = 1'b0;
  logic [DW-1:0] cdat = '0, ddat = '0;
  logic          derq = 1'b0, nerq = 1'b0;

  logic dbgen, spiden, eok, der, ner;
  logic [1:0] stat;
  logic dbgen_n, spiden_n, eok_n, der_n, ner_n;
  logic [1:0] stat_n;

  always #(CLK_P/2) clk = ~clk;

  dbg_prot_ctrl #(.DW(DW), .HAS_SECURE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .nv_dbg_lock_i(nv_d), .nv_sec_lock_i(nv_s), .nv_erase_lock_i(nv_e),
    .cpu_we_i(cwe), .cpu_sel_i(csel), .cpu_wdata_i(cdat),
    .dbg_we_i(dwe), .dbg_sel_i(dsel), .dbg_wdata_i(ddat),
    .dbg_erase_req_i(derq), .nvm_erase_req_i(nerq),
    .dbgen_o(dbgen), .spiden_o(spiden), .erase_ok_o(eok),
    .dbg_erase_o(der), .nvm_erase_o(ner), .status_o(stat));

  dbg_prot_ctrl #(.DW(DW), .HAS_SECURE(1'b0)) uut_ns (
    .clk_i(clk), .rst_ni(rst_ni),
    .nv_dbg_lock_i(nv_d), .nv_sec_lock_i(nv_s), .nv_erase_lock_i(nv_e),
    .cpu_we_i(cwe), .cpu_sel_i(csel), .cpu_wdata_i(cdat),
    .dbg_we_i(dwe), .dbg_sel_i(dsel), .dbg_wdata_i(ddat),
    .dbg_erase_req_i(derq), .nvm_erase_req_i(nerq),
    .dbgen_o(dbgen_n), .spiden_o(spiden_n), .erase_ok_o(eok_n),
    .dbg_erase_o(der_n), .nvm_erase_o(ner_n), .status_o(stat_n));

  typedef struct {
    logic  en, sp, ok, de, ne;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  // reference state
  logic [DW-1:0] m_cns, m_cs, m_dns, m_ds;
  logic          m_valid, m_ld, m_ls, m_le;

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic cw, input logic cs, input logic [DW-1:0] cd,
                      input logic dw, input logic ds, input logic [DW-1:0] dd,
                      input logic er, input logic nr, input string tag);
    exp_t e;
    logic en, sp, ok;
    @(negedge clk);
    cwe = cw; csel = cs; cdat = cd; dwe = dw; dsel = ds; ddat = dd; derq = er; nerq = nr;
    if (cw) begin if (cs) m_cs = cd; else m_cns = cd; end
    if (dw) begin if (ds) m_ds = dd; else m_dns = dd; end
    en = m_valid && !m_ld && (m_cns == m_dns);
    sp = en && !m_ls && (m_cs == m_ds);
    ok = m_valid && !m_le;
    e.en = en; e.sp = sp; e.ok = ok; e.de = er && ok; e.ne = nr && ok; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic do_reset(input logic ld, input logic ls, input logic le);
    @(negedge clk);
    cwe = 0; dwe = 0; derq = 0; nerq = 0;
    rst_ni = 1'b0; nv_d = ld; nv_s = ls; nv_e = le;
    #(CLK_P/4);
    chk("R1 reset outputs", {dbgen, spiden, eok, der, ner}, 5'b0);
    m_cns = '0; m_cs = '0; m_dns = '0; m_ds = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk); #(CLK_P/4);
    chk("R6 before capture", {dbgen, spiden, eok, dbgen_n, eok_n}, 5'b0);
    m_valid = 1'b1; m_ld = ld; m_ls = ls; m_le = le;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, {dbgen, spiden, eok, der, ner}, {e.en, e.sp, e.ok, e.de, e.ne});
        chk({e.tag, " R7 status"}, {3'b0, stat}, {3'b0, e.sp, e.en});
        chk({e.tag, " R11 no-secure variant"}, {dbgen_n, spiden_n, eok_n, der_n, ner_n},
            {e.en, 1'b0, e.ok, e.de, e.ne});
      end
    end
  end

  initial begin
    m_valid = 1'b0; m_ld = 1'b1; m_ls = 1'b1; m_le = 1'b1;
    m_cns = '0; m_cs = '0; m_dns = '0; m_ds = '0;
    do_reset(1'b0, 1'b0, 1'b0);
    idle("R1 regs zero after reset");
    step(1, 0, 32'h5, 0, 0, '0, 0, 0, "R2 cpu ns mismatch");
    step(0, 0, '0, 1, 0, 32'h5, 0, 0, "R8 dbg ns match same edge");
    step(1, 1, 32'hA, 0, 0, '0, 0, 0, "R10 R3 cpu sec write only");
    step(0, 0, '0, 1, 1, 32'hA, 1, 1, "R3 R5 sec match with erase reqs");
    step(1, 0, 32'h7, 1, 0, 32'h7, 0, 1, "R9 dual write same reg");
    step(1, 0, 32'h8, 1, 1, 32'h8, 1, 0, "R9 dual write split target");
    step(0, 0, '0, 1, 0, 32'h8, 0, 0, "R4 ns match sec mismatch");
    step(1, 1, 32'h8, 0, 0, '0, 0, 0, "R3 sec rematch");
    nv_d = 1'b1; nv_s = 1'b1; nv_e = 1'b1;
    idle("R6 lock change ignored");
    step(0, 0, '0, 0, 0, '0, 1, 1, "R6 erase still allowed");
    do_reset(1'b1, 1'b0, 1'b0);
    idle("R2 R4 debug lock set");
    step(1, 0, 32'h0, 1, 0, 32'h0, 1, 0, "R2 locked despite equal");
    do_reset(1'b0, 1'b1, 1'b0);
    idle("R3 secure lock set");
    do_reset(1'b0, 1'b0, 1'b1);
    step(0, 0, '0, 0, 0, '0, 1, 1, "R5 erase lock blocks both");
    step(1, 0, 32'h3, 1, 0, 32'h3, 0, 1, "R5 erase lock with writes");
    idle("final idle");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule